// File: doc/BRIEF.md
# Masked SIMD Word Dot-Product Accumulator

This block performs a packed signed 16-bit dot-product-accumulate across a vector of up to 512 bits. The vector is cut into 32-bit lanes. Each lane takes two signed 16-bit values from the first source. It multiplies them by the two signed 16-bit halves of one 32-bit word of the second source. Both products are added to the lane's existing 32-bit accumulator value, and the sum wraps at 32 bits.

A per-lane write mask chooses which lanes take the new sum. A lane that is masked off is either cleared or keeps its old accumulator value. A broadcast flag makes every lane use the lowest 32-bit word of the second source. A length select sets how many lanes are active, and everything above that length is forced to zero.

The caller presents all operands with a one-cycle `start` pulse. The operands are registered on that edge. The full-width result appears on the next edge, together with a one-cycle `res_valid` strobe.

Top module: `dpacc_top`

## Requirements
- R1: `vlen_sel` picks the active lane count: 2'b00 gives 4 lanes (128 bits), 2'b01 gives 8 lanes (256 bits), and 2'b10 or 2'b11 gives 16 lanes (512 bits).
- R2: An active, written lane i equals acc_in[32i+:32] + s(src1[32i+:16])·s(w[15:0]) + s(src1[32i+16+:16])·s(w[31:16]). Here s() is sign extension and w is the second-source word chosen for that lane.
- R3: Each lane's arithmetic wraps modulo 2^32 with no saturation. For example, (-32768)·(-32768) taken twice with a zero accumulator gives 32'h8000_0000.
- R4: With `bcast`=1, every lane uses w = src2[31:0]. With `bcast`=0, lane i uses w = src2[32i+:32].
- R5: With `mask_en`=0, every active lane is written with its sum, whatever `mask` holds.
- R6: With `mask_en`=1, an active lane whose `mask` bit i is 0 outputs zero when `zero_en`=1.
- R7: With `mask_en`=1, an active lane whose `mask` bit i is 0 outputs its original acc_in word when `zero_en`=0.
- R8: Result bits at or above the selected vector length, up to bit 511, are zero.
- R9: `mask` bits at positions equal to or above the active lane count have no effect on `res`.
- R10: Operands are captured on the rising edge where `start`=1. `res` updates and `res_valid` is 1 on the next rising edge. `res_valid` is 0 otherwise, and `res` holds its value while no result is produced.
- R11: Synchronous active-high `rst` clears `res` to zero and `res_valid` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Capture operands this edge |
| vlen_sel | input | 2 | Vector length select |
| mask_en | input | 1 | Apply per-lane mask |
| zero_en | input | 1 | Masked lanes cleared (1) or merged (0) |
| bcast | input | 1 | Use lowest second-source word for all lanes |
| mask | input | 16 | Per-lane write mask |
| acc_in | input | 512 | Accumulator / original destination |
| src1 | input | 512 | First source, packed signed 16-bit |
| src2 | input | 512 | Second source, packed signed 16-bit |
| res | output | 512 | Registered result vector |
| res_valid | output | 1 | Result strobe, one cycle |

## Verification
A corrupt captured operand or length code shows up on `res` on the very next edge after `start`. It appears as a lane value that disagrees with the reference sum, a masked lane that is neither zero nor its old value, or nonzero bits above the active length. A wrong valid pipeline shows as a strobe that is missing, late or stretched, or as `res` changing on an edge without a strobe. Both are visible within one cycle of the next operation.

// File: rtl/dpacc_pkg.sv
package dpacc_pkg;

  typedef enum logic [1:0] {
    VLEN_Q   = 2'b00,
    VLEN_H   = 2'b01,
    VLEN_F   = 2'b10,
    VLEN_F_X = 2'b11
  } vlen_e;

  // active lane count for a given length code and maximum lane count
  function automatic int unsigned lanes_for(input logic [1:0] code, input int unsigned lanes_max);
    case (code)
      VLEN_Q:  return lanes_max / 4;
      VLEN_H:  return lanes_max / 2;
      default: return lanes_max;
    endcase
  endfunction

endpackage

// File: rtl/dpacc_capture.sv
module dpacc_capture #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         q_valid
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q       <= '0;
      q_valid <= 1'b0;
    end else begin
      q_valid <= load;
      if (load) q <= d;
    end
  end

  // R10: a start pulse yields a staged request on the next edge
  p_capture_r10: assert property (@(posedge clk) disable iff (rst)
    load |=> q_valid);

  p_capture_data_r10: assert property (@(posedge clk) disable iff (rst)
    load |=> q == $past(d));

endmodule

// File: rtl/dpacc_lane.sv
module dpacc_lane #(
  parameter int unsigned LANE_W = 32
) (
  input  logic              active,
  input  logic              wr_en,
  input  logic              zero_en,
  input  logic [LANE_W-1:0] acc,
  input  logic [LANE_W-1:0] a_pair,
  input  logic [LANE_W-1:0] b_pair,
  output logic [LANE_W-1:0] y
);

  localparam int unsigned EW = LANE_W / 2;

  logic signed [EW-1:0]     a_lo, a_hi, b_lo, b_hi;
  logic signed [LANE_W-1:0] prod_lo, prod_hi;
  logic        [LANE_W-1:0] sum;

  always_comb begin
    a_lo    = a_pair[EW-1:0];
    a_hi    = a_pair[LANE_W-1:EW];
    b_lo    = b_pair[EW-1:0];
    b_hi    = b_pair[LANE_W-1:EW];
    prod_lo = LANE_W'(a_lo) * LANE_W'(b_lo);
    prod_hi = LANE_W'(a_hi) * LANE_W'(b_hi);
    sum     = acc + LANE_W'(prod_lo) + LANE_W'(prod_hi);
    if (!active)     y = '0;
    else if (wr_en)  y = sum;
    else if (zero_en) y = '0;
    else             y = acc;
  end

endmodule

// File: rtl/dpacc_top.sv
module dpacc_top #(
  parameter int unsigned VL_MAX = 512,
  parameter int unsigned LANE_W = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start,
  input  logic [1:0]                 vlen_sel,
  input  logic                       mask_en,
  input  logic                       zero_en,
  input  logic                       bcast,
  input  logic [VL_MAX/LANE_W-1:0]   mask,
  input  logic [VL_MAX-1:0]          acc_in,
  input  logic [VL_MAX-1:0]          src1,
  input  logic [VL_MAX-1:0]          src2,
  output logic [VL_MAX-1:0]          res,
  output logic                       res_valid
);
  import dpacc_pkg::*;

  localparam int unsigned LANES = VL_MAX / LANE_W;
  localparam int unsigned CNT_W = $clog2(LANES) + 1;
  localparam int unsigned REQ_W = 3 * VL_MAX + LANES + 5;

  logic [REQ_W-1:0]  req_d, req_q;
  logic              stg_valid;
  logic [VL_MAX-1:0] q_acc, q_s1, q_s2;
  logic [LANES-1:0]  q_mask;
  logic [1:0]        q_vsel;
  logic              q_men, q_zen, q_bc;
  logic [CNT_W-1:0]  n_active;
  logic [VL_MAX-1:0] lane_y;

  assign req_d = {acc_in, src1, src2, mask, vlen_sel, mask_en, zero_en, bcast};

  dpacc_capture #(.W(REQ_W)) u_cap (
    .clk     (clk),
    .rst     (rst),
    .load    (start),
    .d       (req_d),
    .q       (req_q),
    .q_valid (stg_valid)
  );

  assign {q_acc, q_s1, q_s2, q_mask, q_vsel, q_men, q_zen, q_bc} = req_q;
  assign n_active = CNT_W'(lanes_for(q_vsel, LANES));

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] b_word;
    logic              act;
    assign b_word = q_bc ? q_s2[LANE_W-1:0] : q_s2[i*LANE_W +: LANE_W];
    assign act    = (CNT_W'(i) < n_active);

    dpacc_lane #(.LANE_W(LANE_W)) u_lane (
      .active  (act),
      .wr_en   (!q_men || q_mask[i]),
      .zero_en (q_zen),
      .acc     (q_acc[i*LANE_W +: LANE_W]),
      .a_pair  (q_s1[i*LANE_W +: LANE_W]),
      .b_pair  (b_word),
      .y       (lane_y[i*LANE_W +: LANE_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res       <= '0;
      res_valid <= 1'b0;
    end else begin
      res_valid <= stg_valid;
      if (stg_valid) res <= lane_y;
    end
  end

  p_strobe_r10: assert property (@(posedge clk) disable iff (rst)
    stg_valid |=> res_valid);

  p_no_strobe_r10: assert property (@(posedge clk) disable iff (rst)
    !stg_valid |=> !res_valid);

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !stg_valid |=> $stable(res));

  p_upper_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (stg_valid && q_vsel == VLEN_Q) |=> res[VL_MAX-1:VL_MAX/4] == '0);

  p_merge_r7: assert property (@(posedge clk) disable iff (rst)
    (stg_valid && q_men && !q_mask[0] && !q_zen) |=> res[LANE_W-1:0] == $past(q_acc[LANE_W-1:0]));

  p_zeroing_r6: assert property (@(posedge clk) disable iff (rst)
    (stg_valid && q_men && !q_mask[0] && q_zen) |=> res[LANE_W-1:0] == '0);

  p_nomask_r5: assert property (@(posedge clk) disable iff (rst)
    (stg_valid && !q_men && q_s1[LANE_W-1:0] == '0) |=> res[LANE_W-1:0] == $past(q_acc[LANE_W-1:0]));

endmodule

// File: tb/dpacc_top_test.sv
module dpacc_top_test;

  logic         clk = 1'b0;
  logic         rst;
  logic         start;
  logic [1:0]   vlen_sel;
  logic         mask_en, zero_en, bcast;
  logic [15:0]  mask;
  logic [511:0] acc_in, src1, src2;
  logic [511:0] res;
  logic         res_valid;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  dpacc_top uut (
    .clk(clk), .rst(rst), .start(start), .vlen_sel(vlen_sel),
    .mask_en(mask_en), .zero_en(zero_en), .bcast(bcast), .mask(mask),
    .acc_in(acc_in), .src1(src1), .src2(src2), .res(res), .res_valid(res_valid)
  );

  typedef struct packed {
    logic [31:0] seed;
    logic [1:0]  vs;
    logic        men;
    logic        zen;
    logic        bc;
    logic [15:0] msk;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t TAB [NVEC] = '{
    '{32'h0000_1234, 2'd0, 1'b0, 1'b0, 1'b0, 16'h0000},
    '{32'h0bad_cafe, 2'd1, 1'b0, 1'b0, 1'b0, 16'hffff},
    '{32'h1357_9bdf, 2'd2, 1'b0, 1'b0, 1'b0, 16'h0000},
    '{32'h2468_ace0, 2'd3, 1'b1, 1'b0, 1'b0, 16'ha5c3},
    '{32'h5555_aaaa, 2'd2, 1'b1, 1'b1, 1'b0, 16'h3c96},
    '{32'h7777_0001, 2'd1, 1'b1, 1'b1, 1'b1, 16'h00b4},
    '{32'h9abc_def0, 2'd0, 1'b1, 1'b0, 1'b1, 16'hfff6},
    '{32'hdead_beef, 2'd2, 1'b0, 1'b1, 1'b1, 16'h1111},
    '{32'hface_0ff1, 2'd1, 1'b1, 1'b0, 1'b0, 16'h0f0f},
    '{32'h0102_0304, 2'd3, 1'b1, 1'b1, 1'b1, 16'h8001}
  };

  function automatic logic [511:0] gen(input logic [31:0] seed);
    logic [511:0] v;
    logic [31:0]  x;
    x = seed | 32'h1;
    for (int k = 0; k < 16; k++) begin
      x = x ^ (x << 13);
      x = x ^ (x >> 17);
      x = x ^ (x << 5);
      v[32*k +: 32] = x;
    end
    return v;
  endfunction

  // behavioural reference from the requirements
  function automatic logic [511:0] model(
    input logic [511:0] a, input logic [511:0] x, input logic [511:0] y,
    input logic [15:0] m, input logic [1:0] vs, input logic men,
    input logic zen, input logic bc);
    logic [511:0] out;
    int nl;
    nl  = (vs == 2'd0) ? 4 : (vs == 2'd1) ? 8 : 16;
    out = '0;
    for (int i = 0; i < nl; i++) begin
      logic [31:0] w;
      longint      t;
      int          x0, x1, y0, y1;
      w  = bc ? y[31:0] : y[32*i +: 32];
      x0 = $signed(x[32*i +: 16]);
      x1 = $signed(x[32*i+16 +: 16]);
      y0 = $signed(w[15:0]);
      y1 = $signed(w[31:16]);
      t  = longint'(a[32*i +: 32]) + longint'(x0) * longint'(y0) + longint'(x1) * longint'(y1);
      if (!men || m[i])  out[32*i +: 32] = t[31:0];
      else if (zen)      out[32*i +: 32] = 32'h0;
      else               out[32*i +: 32] = a[32*i +: 32];
    end
    return out;
  endfunction

  task automatic chk(input string req, input logic [511:0] act, input logic [511:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // one operation: R10 timing, result against the reference, hold afterwards
  task automatic run_op(input logic [511:0] a, input logic [511:0] x, input logic [511:0] y,
                        input logic [15:0] m, input logic [1:0] vs, input logic men,
                        input logic zen, input logic bc, input string req,
                        output logic [511:0] got);
    logic [511:0] exp;
    exp = model(a, x, y, m, vs, men, zen, bc);
    @(negedge clk);
    acc_in = a; src1 = x; src2 = y; mask = m; vlen_sel = vs;
    mask_en = men; zero_en = zen; bcast = bc; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    acc_in = ~a; src1 = ~x; src2 = ~y;
    chk("R10 no early strobe", {511'b0, res_valid}, 512'd0);
    @(negedge clk);
    chk("R10 strobe", {511'b0, res_valid}, 512'd1);
    chk(req, res, exp);
    got = res;
    @(negedge clk);
    chk("R10 strobe one cycle", {511'b0, res_valid}, 512'd0);
    chk("R10 hold", res, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [511:0] got, a, x, y, exp;
    rst = 1'b1; start = 1'b0; vlen_sel = 2'd0; mask_en = 1'b0; zero_en = 1'b0;
    bcast = 1'b0; mask = '0; acc_in = '0; src1 = '0; src2 = '0;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 res", res, '0);
    chk("R11 valid", {511'b0, res_valid}, '0);
    rst = 1'b0;

    // table walk: R1 R2 R4 R5 R6 R7 R8 R9
    for (int t = 0; t < NVEC; t++) begin
      run_op(gen(TAB[t].seed), gen(TAB[t].seed ^ 32'h5a5a), gen(TAB[t].seed + 32'h77),
             TAB[t].msk, TAB[t].vs, TAB[t].men, TAB[t].zen, TAB[t].bc,
             "R1/R2 table", got);
    end

    // R2: hand value, lane0 = 10 + 3*5 + (-2)*7 = 11
    a = '0; a[31:0] = 32'd10;
    x = '0; x[31:0] = {16'hfffe, 16'h0003};
    y = '0; y[31:0] = {16'h0007, 16'h0005};
    run_op(a, x, y, 16'h0, 2'd0, 1'b0, 1'b0, 1'b0, "R2 hand", got);
    exp = '0; exp[31:0] = 32'd11;
    chk("R2 literal", got, exp);

    // R3: (-32768)^2 twice, then wrap through accumulator
    x = {32{16'h8000}};
    y = {32{16'h8000}};
    run_op('0, x, y, 16'h0, 2'd0, 1'b0, 1'b0, 1'b0, "R3 big product", got);
    exp = '0; exp[127:0] = {4{32'h8000_0000}};
    chk("R3 literal", got, exp);
    run_op({16{32'h8000_0000}}, x, y, 16'h0, 2'd0, 1'b0, 1'b0, 1'b0, "R3 wrap", got);
    chk("R3 wrap literal", got, '0);

    // R4: broadcast word (1,1); lane i has words (i,0) -> lane value i
    x = '0;
    for (int i = 0; i < 16; i++) x[32*i +: 16] = 16'(i);
    y = gen(32'h4444); y[31:0] = 32'h0001_0001;
    run_op('0, x, y, 16'h0, 2'd2, 1'b0, 1'b0, 1'b1, "R4 bcast", got);
    exp = '0;
    for (int i = 0; i < 16; i++) exp[32*i +: 32] = 32'(i);
    chk("R4 literal", got, exp);

    // R9: only high mask bits set, merge -> active lanes keep acc
    a = gen(32'h9999);
    run_op(a, gen(32'h1), gen(32'h2), 16'hfff0, 2'd0, 1'b1, 1'b0, 1'b0, "R9 high mask", got);
    exp = '0; exp[127:0] = a[127:0];
    chk("R9 literal", got, exp);

    // R6: zeroing with empty mask clears everything
    run_op(gen(32'h3), gen(32'h4), gen(32'h5), 16'h0, 2'd2, 1'b1, 1'b1, 1'b0, "R6 zeroing", got);
    chk("R6 literal", got, '0);

    // R8: all-ones accumulator, zero products, 256-bit length
    run_op({512{1'b1}}, '0, gen(32'h6), 16'h0, 2'd1, 1'b0, 1'b0, 1'b0, "R8 upper zero", got);
    exp = '0; exp[255:0] = {256{1'b1}};
    chk("R8 literal", got, exp);

    // R5: mask_en=0 ignores empty mask
    run_op(gen(32'h7), gen(32'h8), gen(32'h9), 16'h0, 2'd3, 1'b0, 1'b1, 1'b0, "R5 mask off", got);

    // random mix
    for (int r = 0; r < 40; r++) begin
      logic [31:0] s;
      s = $urandom;
      run_op(gen(s), gen(s ^ 32'h1111), gen(s + 32'h3), 16'($urandom),
             2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), "R1/R2 random", got);
    end

    // R11: reset after activity
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    chk("R11 res after", res, '0);
    chk("R11 valid after", {511'b0, res_valid}, '0);
    rst = 1'b0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule